// File: doc/BRIEF.md
# Multi-Level DMA Bus Request Mapper

This block collects the bus access requests of sixteen DMA channels, arranged as two transfer engines of eight channels each, together with two side requesters that share the same bus master port: a serial-link requester and a debug requester. Each requester is mapped onto one of three priority request lines (low, medium, high) that the master port raises toward the on-chip bus. The block also picks the single requester that the port serves next.

Channel `i` is requester index `i` (engine 0 owns indices 0 to 7 and engine 1 owns indices 8 to 15). The serial link is index 16 and the debug requester is index 17. The winner is taken from the highest pending level and, within that level, in round-robin order. The grant is held until the transfer completes. Each granted access carries a supervisor attribute and a lock attribute. A locked access aimed at the peripheral-interface side is refused instead of issued.

Top module: `dma_bus_req_mapper`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all outputs are zero: `gnt_valid`, `gnt_onehot`, `gnt_idx`, the three bus lines, `attr_sv`, `attr_lock`, `cfg_err` and `lock_err`.
- R2: A channel's 2-bit field in `ch_prio[2i+1:2i]` selects its level: 2'b11 is high, 2'b01 is medium and 2'b00 is low.
- R3: Field value 2'b10 is treated as low. If the field holds 2'b10 while that channel is not granted, `cfg_err[i]` is set one cycle later and stays set until reset.
- R4: The serial link (index 16) is always low. The debug requester (index 17) is high when `dbg_hi` is 1 and low when it is 0. It is never medium.
- R5: Each of `bus_req_lo`, `bus_req_med` and `bus_req_hi` is registered. It is 1 one cycle after a cycle in which at least one pending requester is mapped to that level.
- R6: When the block is idle and requests are pending, the new grant goes to a requester of the highest pending level.
- R7: Within a level, the search starts at the index after the last index granted at that level, wrapping from 17 to 0. After reset, the search starts at index 0.
- R8: The grant (`gnt_valid`, `gnt_onehot`, 5-bit `gnt_idx`) is registered and appears one cycle after the request is sampled. It holds until `xfer_done` is sampled high while granted, and then drops for one cycle. Outside a grant, `gnt_onehot` and `gnt_idx` are zero and `xfer_done` has no effect.
- R9: A granted requester keeps the level it had when granted. Changes to its priority field or to `dbg_hi` during the grant do not move its bus line.
- R10: `attr_sv` (supervisor mode) is 1 on every cycle that `gnt_valid` is 1.
- R11: A channel with `ch_req`, `ch_lock` and `ch_periph` all high is never granted, and `lock_err[i]` is 1 one cycle later. A granted channel with `ch_lock` high and `ch_periph` low is issued with `attr_lock` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | 16 | Channel request, one bit per channel |
| ch_prio | input | 32 | Channel priority fields, 2 bits per channel |
| ch_lock | input | 16 | Channel requests a locked read-modify-write |
| ch_periph | input | 16 | Channel access targets the peripheral-interface side |
| lnk_req | input | 1 | Serial-link requester |
| dbg_req | input | 1 | Debug requester |
| dbg_hi | input | 1 | Debug level select: 1 high, 0 low |
| xfer_done | input | 1 | Granted transfer completes |
| bus_req_lo | output | 1 | Low-priority bus request line |
| bus_req_med | output | 1 | Medium-priority bus request line |
| bus_req_hi | output | 1 | High-priority bus request line |
| gnt_valid | output | 1 | A grant is active |
| gnt_onehot | output | 18 | One-hot grant vector |
| gnt_idx | output | 5 | Encoded grant index |
| attr_sv | output | 1 | Supervisor-mode attribute |
| attr_lock | output | 1 | Locked-access attribute of the granted channel |
| cfg_err | output | 16 | Sticky reserved-encoding flag per channel |
| lock_err | output | 16 | Refused locked peripheral access per channel |

## Verification
Several channels that all sit at one level, released in turn, show whether rotation resumes after the last winner or restarts at index zero. A mix of high, medium and low requesters shows whether the level order or the index order decides the winner. A priority field rewritten during a grant separates a level captured at grant time from one read live. Locked requests, aimed in turn at the peripheral side and elsewhere, show refusal apart from issue. Random request, field and completion traffic then drives the pointers of all three levels through their wrap points while a behavioural model is compared on every clock.

// File: rtl/dma_map_pkg.sv
package dma_map_pkg;

  typedef enum logic [1:0] {
    LVL_LO  = 2'd0,
    LVL_MED = 2'd1,
    LVL_HI  = 2'd2
  } lvl_e;

  // Channel field decode: 11 high, 01 medium, anything else low.
  function automatic lvl_e map_field(input logic [1:0] f);
    case (f)
      2'b11:   return LVL_HI;
      2'b01:   return LVL_MED;
      default: return LVL_LO;
    endcase
  endfunction

endpackage

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
  parameter int NREQ  = 18,
  parameter int IDX_W = 5
) (
  input  logic [NREQ-1:0]  cand,
  input  logic [IDX_W-1:0] last,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // Scan from last+1 around the ring; first candidate found wins.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 1; k <= NREQ; k++) begin
      int j;
      j = int'(last) + k;
      if (j >= NREQ) j = j - NREQ;
      if (!hit && cand[j]) begin
        hit = 1'b1;
        idx = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/dma_req_map.sv
module dma_req_map
  import dma_map_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int NREQ  = 18,
  parameter int IDX_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH-1:0]      ch_req,
  input  logic [2*NCH-1:0]    ch_prio,
  input  logic [NCH-1:0]      ch_lock,
  input  logic [NCH-1:0]      ch_periph,
  input  logic                lnk_req,
  input  logic                dbg_req,
  input  logic                dbg_hi,
  input  logic                gnt_valid,
  input  logic [IDX_W-1:0]    gnt_idx,
  input  lvl_e                gnt_lvl,
  output logic [NREQ-1:0]     pend,
  output logic [2*NREQ-1:0]   lvl_flat,
  output logic [NREQ-1:0]     lock_vec,
  output logic [NCH-1:0]      cfg_err,
  output logic [NCH-1:0]      lock_err
);

  localparam int LNK_IDX = NCH;
  localparam int DBG_IDX = NCH + 1;

  // Per-channel mapping, refusal and error flags
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic held;
    lvl_e live;
    logic refused;

    assign held    = gnt_valid && (gnt_idx == IDX_W'(c));
    assign live    = map_field(ch_prio[2*c +: 2]);
    assign refused = ch_lock[c] && ch_periph[c];

    assign pend[c]            = ch_req[c] && !refused;
    assign lvl_flat[2*c +: 2] = held ? gnt_lvl : live;
    assign lock_vec[c]        = ch_lock[c];

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_err[c]  <= 1'b0;
        lock_err[c] <= 1'b0;
      end else begin
        if (!held && (ch_prio[2*c +: 2] == 2'b10)) cfg_err[c] <= 1'b1;
        lock_err[c] <= ch_req[c] && refused;
      end
    end
  end

  // Side requesters: serial link fixed low, debug high or low
  logic lnk_held;
  logic dbg_held;
  lvl_e dbg_live;

  assign lnk_held = gnt_valid && (gnt_idx == IDX_W'(LNK_IDX));
  assign dbg_held = gnt_valid && (gnt_idx == IDX_W'(DBG_IDX));
  assign dbg_live = dbg_hi ? LVL_HI : LVL_LO;

  assign pend[LNK_IDX]              = lnk_req;
  assign pend[DBG_IDX]              = dbg_req;
  assign lvl_flat[2*LNK_IDX +: 2]   = lnk_held ? gnt_lvl : LVL_LO;
  assign lvl_flat[2*DBG_IDX +: 2]   = dbg_held ? gnt_lvl : dbg_live;
  assign lock_vec[LNK_IDX]          = 1'b0;
  assign lock_vec[DBG_IDX]          = 1'b0;

endmodule

// File: rtl/dma_gnt_ctrl.sv
module dma_gnt_ctrl
  import dma_map_pkg::*;
#(
  parameter int NREQ  = 18,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREQ-1:0]   pend,
  input  logic [2*NREQ-1:0] lvl_flat,
  input  logic [NREQ-1:0]   lock_vec,
  input  logic              xfer_done,
  output logic              bus_req_lo,
  output logic              bus_req_med,
  output logic              bus_req_hi,
  output logic              gnt_valid,
  output logic [NREQ-1:0]   gnt_onehot,
  output logic [IDX_W-1:0]  gnt_idx,
  output lvl_e              gnt_lvl,
  output logic              attr_sv,
  output logic              attr_lock
);

  localparam int NLVL = 3;

  logic [NREQ-1:0]  cand [NLVL];
  logic [NLVL-1:0]  any_lvl;
  logic [NLVL-1:0]  hit;
  logic [IDX_W-1:0] pick [NLVL];
  logic [IDX_W-1:0] ptr  [NLVL];

  // Split pending requesters by level and run one ring search per level
  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    always_comb begin
      for (int i = 0; i < NREQ; i++)
        cand[l][i] = pend[i] && (lvl_flat[2*i +: 2] == 2'(l));
    end
    assign any_lvl[l] = |cand[l];

    dma_rr_pick #(.NREQ(NREQ), .IDX_W(IDX_W)) u_pick (
      .cand (cand[l]),
      .last (ptr[l]),
      .hit  (hit[l]),
      .idx  (pick[l])
    );
  end

  lvl_e             sel;
  logic [IDX_W-1:0] sel_idx;
  logic             start;

  always_comb begin
    if (hit[2]) begin
      sel     = LVL_HI;
      sel_idx = pick[2];
    end else if (hit[1]) begin
      sel     = LVL_MED;
      sel_idx = pick[1];
    end else begin
      sel     = LVL_LO;
      sel_idx = pick[0];
    end
    start = !gnt_valid && (|pend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req_lo  <= 1'b0;
      bus_req_med <= 1'b0;
      bus_req_hi  <= 1'b0;
      gnt_valid   <= 1'b0;
      gnt_onehot  <= '0;
      gnt_idx     <= '0;
      gnt_lvl     <= LVL_LO;
      attr_sv     <= 1'b0;
      attr_lock   <= 1'b0;
      for (int l = 0; l < NLVL; l++) ptr[l] <= IDX_W'(NREQ - 1);
    end else begin
      bus_req_lo  <= any_lvl[0];
      bus_req_med <= any_lvl[1];
      bus_req_hi  <= any_lvl[2];
      if (gnt_valid && xfer_done) begin
        gnt_valid  <= 1'b0;
        gnt_onehot <= '0;
        gnt_idx    <= '0;
        attr_sv    <= 1'b0;
        attr_lock  <= 1'b0;
      end else if (start) begin
        gnt_valid  <= 1'b1;
        gnt_onehot <= {{(NREQ-1){1'b0}}, 1'b1} << sel_idx;
        gnt_idx    <= sel_idx;
        gnt_lvl    <= sel;
        attr_sv    <= 1'b1;
        attr_lock  <= lock_vec[sel_idx];
        case (sel)
          LVL_HI:  ptr[2] <= sel_idx;
          LVL_MED: ptr[1] <= sel_idx;
          default: ptr[0] <= sel_idx;
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_bus_req_mapper.sv
module dma_bus_req_mapper
  import dma_map_pkg::*;
#(
  parameter  int NUM_ENG    = 2,
  parameter  int CH_PER_ENG = 8,
  localparam int NCH        = NUM_ENG * CH_PER_ENG,
  localparam int NREQ       = NCH + 2,
  localparam int IDX_W      = $clog2(NREQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    ch_req,
  input  logic [2*NCH-1:0]  ch_prio,
  input  logic [NCH-1:0]    ch_lock,
  input  logic [NCH-1:0]    ch_periph,
  input  logic              lnk_req,
  input  logic              dbg_req,
  input  logic              dbg_hi,
  input  logic              xfer_done,
  output logic              bus_req_lo,
  output logic              bus_req_med,
  output logic              bus_req_hi,
  output logic              gnt_valid,
  output logic [NREQ-1:0]   gnt_onehot,
  output logic [IDX_W-1:0]  gnt_idx,
  output logic              attr_sv,
  output logic              attr_lock,
  output logic [NCH-1:0]    cfg_err,
  output logic [NCH-1:0]    lock_err
);

  logic [NREQ-1:0]   pend;
  logic [2*NREQ-1:0] lvl_flat;
  logic [NREQ-1:0]   lock_vec;
  lvl_e              gnt_lvl;

  dma_req_map #(.NCH(NCH), .NREQ(NREQ), .IDX_W(IDX_W)) u_map (
    .clk       (clk),
    .rst       (rst),
    .ch_req    (ch_req),
    .ch_prio   (ch_prio),
    .ch_lock   (ch_lock),
    .ch_periph (ch_periph),
    .lnk_req   (lnk_req),
    .dbg_req   (dbg_req),
    .dbg_hi    (dbg_hi),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx),
    .gnt_lvl   (gnt_lvl),
    .pend      (pend),
    .lvl_flat  (lvl_flat),
    .lock_vec  (lock_vec),
    .cfg_err   (cfg_err),
    .lock_err  (lock_err)
  );

  dma_gnt_ctrl #(.NREQ(NREQ), .IDX_W(IDX_W)) u_gnt (
    .clk         (clk),
    .rst         (rst),
    .pend        (pend),
    .lvl_flat    (lvl_flat),
    .lock_vec    (lock_vec),
    .xfer_done   (xfer_done),
    .bus_req_lo  (bus_req_lo),
    .bus_req_med (bus_req_med),
    .bus_req_hi  (bus_req_hi),
    .gnt_valid   (gnt_valid),
    .gnt_onehot  (gnt_onehot),
    .gnt_idx     (gnt_idx),
    .gnt_lvl     (gnt_lvl),
    .attr_sv     (attr_sv),
    .attr_lock   (attr_lock)
  );

endmodule

// File: rtl/dma_map_chk.sv
module dma_map_chk #(
  parameter int NCH   = 16,
  parameter int NREQ  = 18,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   ch_lock,
  input logic [NCH-1:0]   ch_periph,
  input logic             lnk_req,
  input logic             dbg_req,
  input logic             dbg_hi,
  input logic             xfer_done,
  input logic             bus_req_lo,
  input logic             bus_req_hi,
  input logic             gnt_valid,
  input logic [NREQ-1:0]  gnt_onehot,
  input logic [IDX_W-1:0] gnt_idx,
  input logic             attr_sv,
  input logic [NCH-1:0]   cfg_err
);

  AST_ONEHOT_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_onehot) && (gnt_valid == (|gnt_onehot))); // R8

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt_idx))); // R8

  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && xfer_done) |=> !gnt_valid); // R8

  AST_SUPERVISOR: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> attr_sv); // R10

  AST_LINK_LOW: assert property (@(posedge clk) disable iff (rst)
    lnk_req |=> bus_req_lo); // R4

  AST_DEBUG_HIGH: assert property (@(posedge clk) disable iff (rst)
    (dbg_req && dbg_hi && !(gnt_valid && gnt_idx == IDX_W'(NCH + 1))) |=> bus_req_hi); // R4

  AST_NO_PERIPH_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_valid) |-> (($past(ch_lock & ch_periph) & gnt_onehot[NCH-1:0]) == '0)); // R11

  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cfg_err & $past(cfg_err)) == $past(cfg_err))); // R3

endmodule

bind dma_bus_req_mapper dma_map_chk #(.NCH(NCH), .NREQ(NREQ), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ch_lock    (ch_lock),
  .ch_periph  (ch_periph),
  .lnk_req    (lnk_req),
  .dbg_req    (dbg_req),
  .dbg_hi     (dbg_hi),
  .xfer_done  (xfer_done),
  .bus_req_lo (bus_req_lo),
  .bus_req_hi (bus_req_hi),
  .gnt_valid  (gnt_valid),
  .gnt_onehot (gnt_onehot),
  .gnt_idx    (gnt_idx),
  .attr_sv    (attr_sv),
  .cfg_err    (cfg_err)
);

// File: tb/tb_dma_bus_req_mapper.sv
`timescale 1ns/1ps
module tb_dma_bus_req_mapper;

  localparam int NCH  = 16;
  localparam int NREQ = 18;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [15:0]     ch_req = '0;
  logic [31:0]     ch_prio = '0;
  logic [15:0]     ch_lock = '0;
  logic [15:0]     ch_periph = '0;
  logic            lnk_req = 1'b0;
  logic            dbg_req = 1'b0;
  logic            dbg_hi = 1'b0;
  logic            man_done = 1'b0;
  logic            auto_done = 1'b0;
  logic            rnd_done = 1'b0;
  logic            xfer_done;
  logic            bus_req_lo, bus_req_med, bus_req_hi;
  logic            gnt_valid;
  logic [17:0]     gnt_onehot;
  logic [4:0]      gnt_idx;
  logic            attr_sv, attr_lock;
  logic [15:0]     cfg_err, lock_err;

  assign xfer_done = auto_done ? rnd_done : man_done;

  always #4 clk = ~clk; // 125 MHz

  dma_bus_req_mapper dut (
    .clk(clk), .rst(rst), .ch_req(ch_req), .ch_prio(ch_prio), .ch_lock(ch_lock),
    .ch_periph(ch_periph), .lnk_req(lnk_req), .dbg_req(dbg_req), .dbg_hi(dbg_hi),
    .xfer_done(xfer_done), .bus_req_lo(bus_req_lo), .bus_req_med(bus_req_med),
    .bus_req_hi(bus_req_hi), .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot),
    .gnt_idx(gnt_idx), .attr_sv(attr_sv), .attr_lock(attr_lock),
    .cfg_err(cfg_err), .lock_err(lock_err)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_gv, m_idx, m_lvl, m_lock;
  int   m_ptr [3];
  int   m_bus [3];
  logic [15:0] m_cfg, m_lerr;

  function automatic int field_lvl(input logic [1:0] f);
    if (f == 2'b11) return 2;
    if (f == 2'b01) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_gv = 0; m_idx = 0; m_lvl = 0; m_lock = 0;
      for (int l = 0; l < 3; l++) begin m_ptr[l] = NREQ - 1; m_bus[l] = 0; end
      m_cfg = '0; m_lerr = '0;
    end else begin
      int lv [NREQ];
      int pd [NREQ];
      int nb [3];
      int any_pd;
      for (int i = 0; i < NREQ; i++) begin
        if (i < NCH) begin
          lv[i] = field_lvl(ch_prio[2*i +: 2]);
          pd[i] = (ch_req[i] && !(ch_lock[i] && ch_periph[i])) ? 1 : 0;
        end else if (i == NCH) begin
          lv[i] = 0; pd[i] = lnk_req ? 1 : 0;
        end else begin
          lv[i] = dbg_hi ? 2 : 0; pd[i] = dbg_req ? 1 : 0;
        end
        if (m_gv != 0 && m_idx == i) lv[i] = m_lvl;
      end
      any_pd = 0;
      for (int l = 0; l < 3; l++) nb[l] = 0;
      for (int i = 0; i < NREQ; i++) if (pd[i] != 0) begin nb[lv[i]] = 1; any_pd = 1; end
      for (int i = 0; i < NCH; i++) begin
        if (ch_prio[2*i +: 2] == 2'b10 && !(m_gv != 0 && m_idx == i)) m_cfg[i] = 1'b1;
        m_lerr[i] = ch_req[i] & ch_lock[i] & ch_periph[i];
      end
      if (m_gv != 0 && xfer_done) begin
        m_gv = 0; m_idx = 0; m_lock = 0;
      end else if (m_gv == 0 && any_pd != 0) begin
        int l;
        int found;
        l = (nb[2] != 0) ? 2 : ((nb[1] != 0) ? 1 : 0);
        found = 0;
        for (int k = 1; k <= NREQ; k++) begin
          int j;
          j = (m_ptr[l] + k) % NREQ;
          if (found == 0 && pd[j] != 0 && lv[j] == l) begin
            found = 1; m_idx = j;
          end
        end
        m_gv = 1; m_lvl = l; m_ptr[l] = m_idx;
        m_lock = (m_idx < NCH) ? int'(ch_lock[m_idx]) : 0;
      end
      for (int l = 0; l < 3; l++) m_bus[l] = nb[l];
    end
  end

  // Compare every cycle, away from the active edge
  logic cmp_en = 1'b0;
  always @(negedge clk) begin
    if (cmp_en) begin
      check("R8 gnt_valid", 32'(gnt_valid), 32'(m_gv));
      check("R7 gnt_idx", 32'(gnt_idx), 32'(m_idx));
      check("R8 gnt_onehot", 32'(gnt_onehot), (m_gv != 0) ? (32'd1 << m_idx) : 32'd0);
      check("R5 bus_req_lo", 32'(bus_req_lo), 32'(m_bus[0]));
      check("R2 bus_req_med", 32'(bus_req_med), 32'(m_bus[1]));
      check("R2 bus_req_hi", 32'(bus_req_hi), 32'(m_bus[2]));
      check("R10 attr_sv", 32'(attr_sv), 32'(m_gv));
      check("R11 attr_lock", 32'(attr_lock), 32'(m_lock));
      check("R3 cfg_err", 32'(cfg_err), 32'(m_cfg));
      check("R11 lock_err", 32'(lock_err), 32'(m_lerr));
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic go_idle();
    ch_req = '0; ch_prio = '0; ch_lock = '0; ch_periph = '0;
    lnk_req = 1'b0; dbg_req = 1'b0; dbg_hi = 1'b0;
    man_done = 1'b1;
    @(negedge clk);
    @(negedge clk);
    man_done = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset gnt_valid", 32'(gnt_valid), 0);
    check("R1 reset bus lines", {29'd0, bus_req_hi, bus_req_med, bus_req_lo}, 0);
    check("R1 reset errors", {cfg_err, lock_err}, 0);
    rst = 1'b0;
    cmp_en = 1'b1;
    @(negedge clk);
    check("R1 first cycle idle", 32'(gnt_onehot), 0);

    // R6 / R2: mixed levels, high wins; R9: field change while granted
    ch_req = 16'h0228;               // ch3 low, ch5 high, ch9 medium
    ch_prio[11:10] = 2'b11;
    ch_prio[19:18] = 2'b01;
    @(negedge clk);
    check("R6 high wins idx", 32'(gnt_idx), 5);
    check("R2 all three lines", {29'd0, bus_req_hi, bus_req_med, bus_req_lo}, 32'b111);
    ch_prio[11:10] = 2'b00;
    @(negedge clk);
    check("R9 captured level keeps hi line", 32'(bus_req_hi), 1);
    check("R8 grant held", 32'(gnt_idx), 5);
    man_done = 1'b1;
    @(negedge clk);
    check("R8 release after done", 32'(gnt_valid), 0);
    man_done = 1'b0;
    @(negedge clk);
    check("R6 medium next", 32'(gnt_idx), 9);
    go_idle();

    // R4: side requesters
    lnk_req = 1'b1; dbg_req = 1'b1; dbg_hi = 1'b1;
    @(negedge clk);
    check("R4 debug high, link low", {29'd0, bus_req_hi, bus_req_med, bus_req_lo}, 32'b101);
    check("R4 debug granted", 32'(gnt_idx), 17);
    go_idle();
    dbg_req = 1'b1; dbg_hi = 1'b0;
    @(negedge clk);
    check("R4 debug low", {29'd0, bus_req_hi, bus_req_med, bus_req_lo}, 32'b001);
    go_idle();

    // R3: reserved encoding
    ch_req[2] = 1'b1; ch_prio[5:4] = 2'b10;
    @(negedge clk);
    check("R3 reserved maps low", 32'(bus_req_lo), 1);
    check("R3 cfg_err set", 32'(cfg_err[2]), 1);
    go_idle();
    @(negedge clk);
    check("R3 cfg_err sticky", 32'(cfg_err[2]), 1);

    // R11: locked access toward peripheral side refused
    ch_req[7] = 1'b1; ch_lock[7] = 1'b1; ch_periph[7] = 1'b1;
    @(negedge clk);
    check("R11 lock_err flagged", 32'(lock_err[7]), 1);
    @(negedge clk);
    check("R11 refused not granted", 32'(gnt_valid), 0);
    go_idle();
    ch_req[8] = 1'b1; ch_lock[8] = 1'b1;
    @(negedge clk);
    check("R11 lock granted idx", 32'(gnt_idx), 8);
    check("R11 attr_lock issued", 32'(attr_lock), 1);
    check("R10 supervisor", 32'(attr_sv), 1);
    go_idle();

    // R7: rotation within one level, explicit order
    ch_req = 16'h0016;               // ch1, ch2, ch4 all low
    man_done = 1'b1;
    for (int n = 0; n < 6; n++) @(negedge clk);
    man_done = 1'b0;
    go_idle();

    // Random traffic, model compared every cycle
    auto_done = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      ch_req    = 16'($urandom) & 16'($urandom);
      ch_prio   = $urandom;
      ch_lock   = 16'($urandom) & 16'($urandom) & 16'($urandom);
      ch_periph = 16'($urandom);
      lnk_req   = ($urandom % 4) == 0;
      dbg_req   = ($urandom % 4) == 0;
      dbg_hi    = $urandom % 2;
      rnd_done  = ($urandom % 3) == 0;
      @(negedge clk);
    end
    auto_done = 1'b0;
    go_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule